// File: doc/BRIEF.md
# Wake-Event Status Collector

This block gathers wake-up and interrupt conditions from a set of sources and holds each one in a sticky status bit. Software clears a bit by writing 1 to its position. The sources are an active-low sleep-button pin, an RTC alarm, a keyboard-controller port line, keyboard and mouse IRQs, a module IRQ, and a watchdog time-out. The module IRQ is the OR of the enabled legacy-device IRQs and a gated external IRQ pin.

All sources are level-sensitive. A status bit whose source is still active when software clears it stays set. The sleep-button and RTC events each set a mirrored pair of bits: one in a power-management register and one in a general-purpose event register. A 1 written to either copy clears both copies. A blanking counter runs on the standby clock from standby power-on reset. It keeps the two standby-domain pins, the sleep button and the external IRQ pin, from producing events until CLK_HZ cycles (one second) have elapsed. Keyboard-controller and legacy-device events count only while main power is present.

Top module: `wake_status_top`

## Requirements
- R1: Each status bit is set one clock after its source condition is active, and it stays set after the source goes inactive.
- R2: A write with a 1 at a bit position clears that status bit. A 0 at a position leaves that bit unchanged.
- R3: If a source is active in the same cycle as a clearing write, its status bit stays set.
- R4: The sleep-button pin is active low. It is ignored until CLK_HZ clock edges have passed since reset release.
- R5: The sleep and RTC bits exist as a PM copy and a GPE copy. A 1 written to either copy clears both copies.
- R6: With rtc_pm_en_i at 0, an RTC alarm sets only the GPE copy of the RTC bit. The PM copy stays 0.
- R7: The module bit is set by any legacy IRQ whose enable bit is 1, but only while main_pwr_i is 1.
- R8: The external IRQ pin sets the module bit only when both of its enables are 1 and blanking has ended. This does not depend on main power.
- R9: The port bit needs main_pwr_i and kbc_en_i. The keyboard and mouse bits each need main_pwr_i and their own IRQ enable.
- R10: A watchdog time-out sets the watchdog bit with the same sticky write-1-clear behaviour.
- R11: Address 0 is the PM register: bit0 is sleep and bit1 is RTC. Address 1 is the GPE register: bit0 sleep, bit1 RTC, bit2 port, bit3 keyboard, bit4 mouse, bit5 module, bit6 watchdog. Unused bits read 0, and all bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Standby-domain clock |
| rst_ni | input | 1 | Standby power-on reset, active low, asynchronous |
| main_pwr_i | input | 1 | Main power present |
| slp_btn_ni | input | 1 | Sleep-button pin, active low |
| rtc_alarm_i | input | 1 | RTC alarm level |
| rtc_pm_en_i | input | 1 | Allows the RTC alarm to set the PM copy |
| kbc_en_i | input | 1 | Keyboard-controller module enabled |
| kbc_port_i | input | 1 | Keyboard-controller port line |
| kbd_irq_i | input | 1 | Keyboard IRQ, active high |
| kbd_irq_en_i | input | 1 | Keyboard IRQ enable |
| ms_irq_i | input | 1 | Mouse IRQ, active high |
| ms_irq_en_i | input | 1 | Mouse IRQ enable |
| leg_irq_i | input | NUM_LEG | Legacy-device IRQs |
| leg_irq_en_i | input | NUM_LEG | Per-device IRQ enables |
| xirq_i | input | 1 | External IRQ pin level |
| xirq_en_i | input | 1 | External IRQ enable |
| xirq_wake_en_i | input | 1 | External IRQ wake enable |
| wdt_to_i | input | 1 | Watchdog time-out level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address (0 PM, 1 GPE) |
| wr_data_i | input | DATA_W | Write data, 1 clears |
| rd_addr_i | input | 1 | Read address (0 PM, 1 GPE) |
| rd_data_o | output | DATA_W | Read data of the addressed register |

## Verification
A source level and a clearing write can land in the same clock. This applies to both copies of a mirrored pair and to single bits. The bench holds the watchdog and RTC levels high across a write of 1 and checks that the bit survives. It then drops the level and repeats the write to see the bit clear. A reference model of the status bits predicts every cycle, and both registers are compared after each edge.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned PM_W   = 2;
  localparam int unsigned GPE_W  = 7;
  localparam int unsigned STAT_W = PM_W + GPE_W;

  typedef enum int unsigned {
    G_SLP  = 0,
    G_RTC  = 1,
    G_PORT = 2,
    G_KBD  = 3,
    G_MS   = 4,
    G_MOD  = 5,
    G_WDO  = 6
  } gpe_bit_e;

  localparam int unsigned PM_SLP = 0;
  localparam int unsigned PM_RTC = 1;
endpackage

// File: rtl/wake_blank_timer.sv
module wake_blank_timer #(
  parameter int unsigned CYCLES = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == CNT_W'(CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_blank_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_blank_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/wake_src_cond.sv
module wake_src_cond
  import wake_pkg::*;
#(
  parameter int unsigned NUM_LEG = 4
) (
  input  logic               blank_done_i,
  input  logic               main_pwr_i,
  input  logic               slp_btn_ni,
  input  logic               rtc_alarm_i,
  input  logic               rtc_pm_en_i,
  input  logic               kbc_en_i,
  input  logic               kbc_port_i,
  input  logic               kbd_irq_i,
  input  logic               kbd_irq_en_i,
  input  logic               ms_irq_i,
  input  logic               ms_irq_en_i,
  input  logic [NUM_LEG-1:0] leg_irq_i,
  input  logic [NUM_LEG-1:0] leg_irq_en_i,
  input  logic               xirq_i,
  input  logic               xirq_en_i,
  input  logic               xirq_wake_en_i,
  input  logic               wdt_to_i,
  output logic [PM_W-1:0]    pm_act_o,
  output logic [GPE_W-1:0]   gpe_act_o
);
  logic slp_act, leg_act, xirq_act;

  assign slp_act  = blank_done_i & ~slp_btn_ni;
  assign leg_act  = main_pwr_i & |(leg_irq_i & leg_irq_en_i);
  assign xirq_act = blank_done_i & xirq_i & xirq_en_i & xirq_wake_en_i;

  always_comb begin
    pm_act_o          = '0;
    pm_act_o[PM_SLP]  = slp_act;
    pm_act_o[PM_RTC]  = rtc_alarm_i & rtc_pm_en_i;
    gpe_act_o         = '0;
    gpe_act_o[G_SLP]  = slp_act;
    gpe_act_o[G_RTC]  = rtc_alarm_i;
    gpe_act_o[G_PORT] = main_pwr_i & kbc_en_i & kbc_port_i;
    gpe_act_o[G_KBD]  = main_pwr_i & kbd_irq_en_i & kbd_irq_i;
    gpe_act_o[G_MS]   = main_pwr_i & ms_irq_en_i & ms_irq_i;
    gpe_act_o[G_MOD]  = leg_act | xirq_act;
    gpe_act_o[G_WDO]  = wdt_to_i;
  end
endmodule

// File: rtl/wake_sticky.sv
module wake_sticky #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= set_i | (q_o & ~clr_i);  // set wins
  end

  p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(clr_i & set_i)) == $past(clr_i & set_i)));
endmodule

// File: rtl/wake_status_top.sv
module wake_status_top
  import wake_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 32768,
  parameter int unsigned NUM_LEG = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               main_pwr_i,
  input  logic               slp_btn_ni,
  input  logic               rtc_alarm_i,
  input  logic               rtc_pm_en_i,
  input  logic               kbc_en_i,
  input  logic               kbc_port_i,
  input  logic               kbd_irq_i,
  input  logic               kbd_irq_en_i,
  input  logic               ms_irq_i,
  input  logic               ms_irq_en_i,
  input  logic [NUM_LEG-1:0] leg_irq_i,
  input  logic [NUM_LEG-1:0] leg_irq_en_i,
  input  logic               xirq_i,
  input  logic               xirq_en_i,
  input  logic               xirq_wake_en_i,
  input  logic               wdt_to_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic               blank_done;
  logic [PM_W-1:0]    pm_act, pm_clr;
  logic [GPE_W-1:0]   gpe_act, gpe_clr;
  logic [STAT_W-1:0]  stat_q;
  logic [PM_W-1:0]    pm_q;
  logic [GPE_W-1:0]   gpe_q;
  logic               wr_pm, wr_gpe;

  wake_blank_timer #(.CYCLES(CLK_HZ)) i_blank (
    .clk_i, .rst_ni, .done_o(blank_done)
  );

  wake_src_cond #(.NUM_LEG(NUM_LEG)) i_cond (
    .blank_done_i(blank_done), .main_pwr_i, .slp_btn_ni, .rtc_alarm_i,
    .rtc_pm_en_i, .kbc_en_i, .kbc_port_i, .kbd_irq_i, .kbd_irq_en_i,
    .ms_irq_i, .ms_irq_en_i, .leg_irq_i, .leg_irq_en_i, .xirq_i,
    .xirq_en_i, .xirq_wake_en_i, .wdt_to_i,
    .pm_act_o(pm_act), .gpe_act_o(gpe_act)
  );

  assign wr_pm  = wr_en_i & ~wr_addr_i;
  assign wr_gpe = wr_en_i &  wr_addr_i;

  // PM bits mirror GPE bits of the same index; a write to either clears both
  for (genvar i = 0; i < PM_W; i++) begin : g_pm_clr
    assign pm_clr[i] = (wr_pm & wr_data_i[i]) | (wr_gpe & wr_data_i[i]);
  end
  for (genvar j = 0; j < GPE_W; j++) begin : g_gpe_clr
    if (j < PM_W) begin : g_pair
      assign gpe_clr[j] = (wr_gpe & wr_data_i[j]) | (wr_pm & wr_data_i[j]);
    end else begin : g_single
      assign gpe_clr[j] = wr_gpe & wr_data_i[j];
    end
  end

  wake_sticky #(.W(STAT_W)) i_stat (
    .clk_i, .rst_ni,
    .set_i({gpe_act, pm_act}),
    .clr_i({gpe_clr, pm_clr}),
    .q_o(stat_q)
  );

  assign pm_q  = stat_q[PM_W-1:0];
  assign gpe_q = stat_q[STAT_W-1:PM_W];

  assign rd_data_o = rd_addr_i ? DATA_W'(gpe_q) : DATA_W'(pm_q);

  p_blank_slp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_done && !pm_q[PM_SLP]) |=> !pm_q[PM_SLP]);
  p_slp_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_q[PM_SLP] == gpe_q[G_SLP]);
  p_rtc_pm_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rtc_pm_en_i && !pm_q[PM_RTC]) |=> !pm_q[PM_RTC]);
  p_no_main_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_pwr_i && !gpe_q[G_PORT]) |=> !gpe_q[G_PORT]);
endmodule

// File: tb/test_wake_status_top.sv
module test_wake_status_top;
  localparam int unsigned BLANK = 20;
  localparam int unsigned NL = 4;

  logic clk = 0, rst_ni = 0;
  logic main_pwr = 0, slp_n = 1, rtc = 0, rtc_pm_en = 1, kbc_en = 0, kbc_port = 0;
  logic kbd = 0, kbd_en = 0, ms = 0, ms_en = 0, xirq = 0, xirq_en = 0, xirq_wen = 0, wdt = 0;
  logic [NL-1:0] leg = '0, leg_en = '0;
  logic we = 0, waddr = 0, raddr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0, n_fail = 0;
  string tag = "R11";

  always #10 clk = ~clk;

  wake_status_top #(.CLK_HZ(BLANK), .NUM_LEG(NL), .DATA_W(8)) i_wake_status_top (
    .clk_i(clk), .rst_ni, .main_pwr_i(main_pwr), .slp_btn_ni(slp_n),
    .rtc_alarm_i(rtc), .rtc_pm_en_i(rtc_pm_en), .kbc_en_i(kbc_en),
    .kbc_port_i(kbc_port), .kbd_irq_i(kbd), .kbd_irq_en_i(kbd_en),
    .ms_irq_i(ms), .ms_irq_en_i(ms_en), .leg_irq_i(leg), .leg_irq_en_i(leg_en),
    .xirq_i(xirq), .xirq_en_i(xirq_en), .xirq_wake_en_i(xirq_wen),
    .wdt_to_i(wdt), .wr_en_i(we), .wr_addr_i(waddr), .wr_data_i(wdata),
    .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  // reference model
  logic [1:0] m_pm;
  logic [6:0] m_gpe;
  int m_cnt;
  logic [1:0] s_pm, c_pm;
  logic [6:0] s_gpe, c_gpe;
  logic m_done;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pm <= '0; m_gpe <= '0; m_cnt <= 0;
    end else begin
      m_done = (m_cnt >= BLANK);
      s_gpe[0] = m_done && !slp_n;
      s_gpe[1] = rtc;
      s_gpe[2] = main_pwr && kbc_en && kbc_port;
      s_gpe[3] = main_pwr && kbd_en && kbd;
      s_gpe[4] = main_pwr && ms_en && ms;
      s_gpe[5] = (main_pwr && ((leg & leg_en) != 0)) || (m_done && xirq && xirq_en && xirq_wen);
      s_gpe[6] = wdt;
      s_pm[0] = s_gpe[0];
      s_pm[1] = rtc && rtc_pm_en;
      c_gpe = we ? (waddr ? wdata[6:0] : {5'b0, wdata[1:0]}) : '0;
      c_pm = we ? wdata[1:0] : '0;
      m_pm <= s_pm | (m_pm & ~c_pm);
      m_gpe <= s_gpe | (m_gpe & ~c_gpe);
      if (m_cnt < BLANK) m_cnt <= m_cnt + 1;
    end
  end

  task automatic cmp(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // advance one clock, then compare both registers against the model
  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      raddr = 0; #1; cmp({tag, " pm"}, rdata, {6'b0, m_pm});
      raddr = 1; #1; cmp({tag, " gpe"}, rdata, {1'b0, m_gpe});
    end
  endtask

  task automatic chk_reg(input logic a, input logic [7:0] exp, input string t);
    raddr = a; #1; cmp(t, rdata, exp);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    we = 1; waddr = a; wdata = d;
    step();
    we = 0; wdata = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1;
    chk_reg(0, 8'h00, "R11 reset pm");
    chk_reg(1, 8'h00, "R11 reset gpe");
    #45 rst_ni = 1;
    // R4: press during blanking is ignored
    tag = "R4"; slp_n = 0; step(5); slp_n = 1; step(1);
    chk_reg(0, 8'h00, "R4 blanked press");
    step(BLANK);
    slp_n = 0; step(2); slp_n = 1; step(1);
    chk_reg(0, 8'h01, "R4 press after blank pm");
    chk_reg(1, 8'h01, "R4 press after blank gpe");
    // R5: clear via GPE copy clears both
    tag = "R5"; wr(1, 8'h01);
    chk_reg(0, 8'h00, "R5 mirror clear pm");
    // R10 / R1: pulse holds
    tag = "R10"; wdt = 1; step(1); wdt = 0; step(3);
    chk_reg(1, 8'h40, "R10 watchdog sticky");
    // R2: writing zeros has no effect
    tag = "R2"; wr(1, 8'h00); wr(0, 8'hBC);
    chk_reg(1, 8'h40, "R2 zero write ignored");
    // R3: clear while active keeps bit
    tag = "R3"; wdt = 1; step(1); wr(1, 8'h40);
    chk_reg(1, 8'h40, "R3 clear while active");
    wdt = 0; step(1); wr(1, 8'h40);
    chk_reg(1, 8'h00, "R2 clear after release");
    // R6: PM copy gated
    tag = "R6"; rtc_pm_en = 0; rtc = 1; step(2); rtc = 0; step(1);
    chk_reg(0, 8'h00, "R6 pm copy gated");
    chk_reg(1, 8'h02, "R6 gpe copy set");
    tag = "R5"; wr(0, 8'h02);
    chk_reg(1, 8'h00, "R5 pm write clears gpe copy");
    rtc_pm_en = 1; rtc = 1; step(1); wr(0, 8'h02);
    chk_reg(0, 8'h02, "R3 rtc pair held while active");
    rtc = 0; step(1); wr(1, 8'h02);
    chk_reg(0, 8'h00, "R5 rtc pair cleared");
    // R9: keyboard-controller gating
    tag = "R9"; kbc_port = 1; kbc_en = 1; main_pwr = 0; step(2);
    main_pwr = 1; kbc_en = 0; step(2);
    chk_reg(1, 8'h00, "R9 port gated");
    kbc_en = 1; step(1); kbc_port = 0; step(1);
    chk_reg(1, 8'h04, "R9 port set");
    kbd = 1; ms = 1; step(2);
    chk_reg(1, 8'h04, "R9 irqs without enable");
    kbd_en = 1; step(1); kbd = 0; ms_en = 1; step(1); ms = 0; step(1);
    chk_reg(1, 8'h1C, "R9 kbd and mouse set");
    wr(1, 8'h1C);
    // R7: legacy IRQs
    tag = "R7"; leg = 4'b0100; leg_en = 4'b1011; step(2);
    chk_reg(1, 8'h00, "R7 disabled device");
    main_pwr = 0; leg_en = 4'b0100; step(2);
    chk_reg(1, 8'h00, "R7 no main power");
    main_pwr = 1; step(1); leg = '0; step(1);
    chk_reg(1, 8'h20, "R7 module set");
    wr(1, 8'h20);
    // R8: external IRQ pin
    tag = "R8"; main_pwr = 0; xirq = 1; xirq_en = 1; step(2);
    xirq_en = 0; xirq_wen = 1; step(2);
    chk_reg(1, 8'h00, "R8 single enable");
    xirq_en = 1; step(1); xirq = 0; step(1);
    chk_reg(1, 8'h20, "R8 pin without main power");
    // R1: multiple sources accumulate
    tag = "R1"; wdt = 1; slp_n = 0; step(1); wdt = 0; slp_n = 1; step(2);
    chk_reg(1, 8'h61, "R1 accumulated");
    tag = "R11"; wr(1, 8'h7F);
    chk_reg(1, 8'h00, "R11 all cleared gpe");
    chk_reg(0, 8'h00, "R11 all cleared pm");
    finish_run();
  end
endmodule